// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This is a purely combinational datapath slice for an 8-bit processor core. In one pass it does three things. It rotates or shifts a byte operand in one of eight ways. It tests a single bit of the operand. It clears or sets a single bit of the operand. It returns the new byte together with the updated flag byte. The sequencer in front of it fetches the operand, picks the operation and writes the result back. None of that sequencing is part of this unit.

Two input controls change only the flags. The first is an accumulator-form control. It selects the short accumulator rotates, which must leave the sign, zero and parity flags exactly as they came in. The second is a memory-form control. It tells the bit test that the operand came from memory. In that case the two undocumented flag copies (X and Y) are taken from the high byte of a hidden internal address register, supplied on its own input, and not from the operand.

Top module: `rsb_unit`

## Requirements

The flag byte uses these positions: S=bit 7, Z=bit 6, Y=bit 5, H=bit 4, X=bit 3, P/V=bit 2, N=bit 1, C=bit 0.

`grp_i` selects the operation class: 0 = rotate/shift, 1 = bit test, 2 = clear bit, 3 = set bit.

`kind_i` selects the rotate/shift: 0 = RLC, 1 = RRC, 2 = RL, 3 = RR, 4 = SLA, 5 = SRA, 6 = SLL, 7 = SRL.

- R1: RLC and RRC rotate the byte circularly (left and right respectively). The bit that leaves the byte also appears in C.
- R2: RL rotates left through the carry, taking the incoming C into bit 0 and moving old bit 7 into C. RR does the mirror image: the incoming C goes into bit 7 and old bit 0 goes into C.
- R3: SLA shifts left with a zero entering bit 0. SRA shifts right and keeps bit 7 unchanged. SRL shifts right with a zero entering bit 7. In each case the bit shifted out goes to C.
- R4: SLL shifts left with a one entering bit 0, and old bit 7 goes to C.
- R5: For a rotate/shift with the accumulator form off:
  - S is set to result bit 7.
  - Z is set when the result is zero.
  - P/V is set when the result has an even number of ones.
  - H and N are cleared.
  - X and Y are copied from result bits 3 and 5.
- R6: With the accumulator form on, S, Z and P/V keep their incoming values. H and N are cleared, C takes the bit shifted out, and X and Y come from the result.
- R7: The bit test returns the operand unchanged.
  - Z and P/V are both set when the selected bit is zero.
  - H is set and N is cleared.
  - C keeps its incoming value.
- R8: For the bit test, S is set only when the index is 7 and operand bit 7 is one.
- R9: For the bit test, X and Y come from operand bits 3 and 5 when the memory form is off. When it is on, they come from bits 3 and 5 of the hidden-address high byte.
- R10: Clear-bit forces the indexed bit to zero and set-bit forces it to one. All other bits are kept, and the flag output equals the flag input.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 8 | Operand byte |
| grp_i | input | 2 | Operation class |
| kind_i | input | 3 | Rotate/shift selector |
| bit_idx_i | input | 3 | Bit index for test/clear/set |
| acc_form_i | input | 1 | Accumulator-rotate flag rule |
| mem_form_i | input | 1 | Operand came from memory (bit test X/Y source) |
| addr_hi_i | input | 8 | High byte of the hidden address register |
| flags_i | input | 8 | Incoming flag byte |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | Outgoing flag byte |

## Verification

The bench targets the fill bits of the four shifts:
- An SLL built like SLA would show a zero in bit 0.
- An SRA that zero-fills would break negative operands.

The through-carry rotates are run with both carry-in values, because a design that ignored C would fail only half of them. Operands 0x00, 0x80 and 0x01 are used because the bit shifted out there decides Z, and a flag generator reading the operand in place of the result would get the zero flag wrong. For the bit test, index 7 exercises the sign rule, and the memory form is run with an address byte whose bits 3 and 5 differ from the operand's. A design with the wrong X/Y source shows the operand's bits instead.

// File: rtl/rsb_pkg.sv
// Shared widths, selectors and flag positions of the rotate/shift/bit unit.
// Assumes an 8-bit flag byte with fixed bit positions.
package rsb_pkg;
    localparam int DW = 8;
    localparam int IW = $clog2(DW);

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLR   = 2'd2,
        GRP_SET   = 2'd3
    } grp_e;

    typedef enum logic [2:0] {
        SK_RLC = 3'd0,
        SK_RRC = 3'd1,
        SK_RL  = 3'd2,
        SK_RR  = 3'd3,
        SK_SLA = 3'd4,
        SK_SRA = 3'd5,
        SK_SLL = 3'd6,
        SK_SRL = 3'd7
    } kind_e;

    localparam int FB_S = 7;
    localparam int FB_Z = 6;
    localparam int FB_Y = 5;
    localparam int FB_H = 4;
    localparam int FB_X = 3;
    localparam int FB_P = 2;
    localparam int FB_N = 1;
    localparam int FB_C = 0;
endpackage

// File: rtl/rsb_shifter.sv
// Rotate/shift datapath: produces the shifted byte and the bit pushed out.
// Assumes the selector encoding in rsb_pkg; purely combinational.
module rsb_shifter
    import rsb_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] opnd_i,
    input  logic [2:0]   kind_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    localparam int MSB = W - 1;

    // Select the fill bit and direction for each rotate/shift kind.
    always_comb begin
        res_o  = opnd_i;
        cout_o = 1'b0;
        case (kind_e'(kind_i))
            SK_RLC: begin res_o = {opnd_i[MSB-1:0], opnd_i[MSB]}; cout_o = opnd_i[MSB]; end
            SK_RRC: begin res_o = {opnd_i[0], opnd_i[MSB:1]};     cout_o = opnd_i[0];   end
            SK_RL:  begin res_o = {opnd_i[MSB-1:0], cin_i};       cout_o = opnd_i[MSB]; end
            SK_RR:  begin res_o = {cin_i, opnd_i[MSB:1]};         cout_o = opnd_i[0];   end
            SK_SLA: begin res_o = {opnd_i[MSB-1:0], 1'b0};        cout_o = opnd_i[MSB]; end
            SK_SRA: begin res_o = {opnd_i[MSB], opnd_i[MSB:1]};   cout_o = opnd_i[0];   end
            SK_SLL: begin res_o = {opnd_i[MSB-1:0], 1'b1};        cout_o = opnd_i[MSB]; end
            SK_SRL: begin res_o = {1'b0, opnd_i[MSB:1]};          cout_o = opnd_i[0];   end
            default: begin res_o = opnd_i; cout_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/rsb_bitop.sv
// Single-bit datapath: decodes the index to a mask, tests, clears or sets.
// Assumes the index is below W; purely combinational.
module rsb_bitop
    import rsb_pkg::*;
#(
    parameter int W  = DW,
    parameter int XW = IW
) (
    input  logic [W-1:0]  opnd_i,
    input  logic [XW-1:0] idx_i,
    input  logic          set_i,
    output logic [W-1:0]  res_o,
    output logic          bit_zero_o,
    output logic          sign_hit_o
);
    logic [W-1:0] mask;

    // One-hot mask, one decoder per bit position.
    for (genvar g = 0; g < W; g++) begin : g_mask
        assign mask[g] = (idx_i == XW'(g));
    end

    // Test result and clear/set of the selected bit.
    always_comb begin
        bit_zero_o = ((opnd_i & mask) == '0);
        sign_hit_o = mask[W-1] & opnd_i[W-1];
        res_o      = set_i ? (opnd_i | mask) : (opnd_i & ~mask);
    end
endmodule

// File: rtl/rsb_flag_gen.sv
// Builds the outgoing flag byte for every operation class.
// Assumes the flag positions in rsb_pkg and an 8-bit data width.
module rsb_flag_gen
    import rsb_pkg::*;
(
    input  logic [1:0]    grp_i,
    input  logic          acc_form_i,
    input  logic          mem_form_i,
    input  logic [DW-1:0] shift_res_i,
    input  logic          shift_cout_i,
    input  logic          bit_zero_i,
    input  logic          sign_hit_i,
    input  logic [DW-1:0] opnd_i,
    input  logic [DW-1:0] addr_hi_i,
    input  logic [7:0]    flags_i,
    output logic [7:0]    flags_o
);
    logic [DW-1:0] xy_src;

    // X/Y source for the bit test: hidden address byte in memory forms.
    always_comb xy_src = mem_form_i ? addr_hi_i : opnd_i;

    // Per-class flag rules.
    always_comb begin
        flags_o = flags_i;
        case (grp_e'(grp_i))
            GRP_SHIFT: begin
                flags_o[FB_H] = 1'b0;
                flags_o[FB_N] = 1'b0;
                flags_o[FB_C] = shift_cout_i;
                flags_o[FB_X] = shift_res_i[3];
                flags_o[FB_Y] = shift_res_i[5];
                if (!acc_form_i) begin
                    flags_o[FB_S] = shift_res_i[DW-1];
                    flags_o[FB_Z] = (shift_res_i == '0);
                    flags_o[FB_P] = ~^shift_res_i;
                end
            end
            GRP_TEST: begin
                flags_o[FB_S] = sign_hit_i;
                flags_o[FB_Z] = bit_zero_i;
                flags_o[FB_P] = bit_zero_i;
                flags_o[FB_H] = 1'b1;
                flags_o[FB_N] = 1'b0;
                flags_o[FB_X] = xy_src[3];
                flags_o[FB_Y] = xy_src[5];
            end
            default: flags_o = flags_i;
        endcase
    end
endmodule

// File: rtl/rsb_unit.sv
// Top of the rotate/shift/bit-test unit: routes the operand through the
// shifter and the bit datapath and picks the result for the selected class.
// Assumes operand fetch and write-back happen outside; combinational only.
module rsb_unit
    import rsb_pkg::*;
(
    input  logic [7:0] opnd_i,
    input  logic [1:0] grp_i,
    input  logic [2:0] kind_i,
    input  logic [2:0] bit_idx_i,
    input  logic       acc_form_i,
    input  logic       mem_form_i,
    input  logic [7:0] addr_hi_i,
    input  logic [7:0] flags_i,
    output logic [7:0] result_o,
    output logic [7:0] flags_o
);
    logic [DW-1:0] sh_res;
    logic          sh_cout;
    logic [DW-1:0] bo_res;
    logic          bo_zero;
    logic          bo_sign;

    rsb_shifter #(.W(DW)) u_shift (
        .opnd_i (opnd_i),
        .kind_i (kind_i),
        .cin_i  (flags_i[FB_C]),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    rsb_bitop #(.W(DW), .XW(IW)) u_bit (
        .opnd_i     (opnd_i),
        .idx_i      (bit_idx_i),
        .set_i      (grp_i == GRP_SET),
        .res_o      (bo_res),
        .bit_zero_o (bo_zero),
        .sign_hit_o (bo_sign)
    );

    rsb_flag_gen u_flag (
        .grp_i        (grp_i),
        .acc_form_i   (acc_form_i),
        .mem_form_i   (mem_form_i),
        .shift_res_i  (sh_res),
        .shift_cout_i (sh_cout),
        .bit_zero_i   (bo_zero),
        .sign_hit_i   (bo_sign),
        .opnd_i       (opnd_i),
        .addr_hi_i    (addr_hi_i),
        .flags_i      (flags_i),
        .flags_o      (flags_o)
    );

    // Result select by operation class; the bit test leaves the byte as is.
    always_comb begin
        case (grp_e'(grp_i))
            GRP_SHIFT: result_o = sh_res;
            GRP_TEST:  result_o = opnd_i;
            default:   result_o = bo_res;
        endcase
    end
endmodule

// File: rtl/rsb_unit_chk.sv
// Checker for rsb_unit: immediate assertions on its ports, evaluated
// whenever all inputs are known. Attached by the bind below.
module rsb_unit_chk (
    input logic [7:0] opnd_i,
    input logic [1:0] grp_i,
    input logic [2:0] kind_i,
    input logic [2:0] bit_idx_i,
    input logic       acc_form_i,
    input logic       mem_form_i,
    input logic [7:0] addr_hi_i,
    input logic [7:0] flags_i,
    input logic [7:0] result_o,
    input logic [7:0] flags_o
);
    // Port-level checks of the flag and result rules.
    always_comb begin
        if (!$isunknown({opnd_i, grp_i, kind_i, bit_idx_i, acc_form_i,
                         mem_form_i, addr_hi_i, flags_i})) begin
            if (grp_i == 2'd0) begin
                assert_shift_hn_clear_R5: assert (flags_o[4] == 1'b0 && flags_o[1] == 1'b0)
                    else $error("shift H/N not cleared");
                assert_shift_xy_result_R5: assert (flags_o[3] == result_o[3] && flags_o[5] == result_o[5])
                    else $error("shift X/Y not from result");
                if (acc_form_i) begin
                    assert_acc_szp_kept_R6: assert (flags_o[7] == flags_i[7] && flags_o[6] == flags_i[6]
                                                     && flags_o[2] == flags_i[2])
                        else $error("accumulator rotate changed S/Z/P");
                end
            end
            if (grp_i == 2'd1) begin
                assert_test_result_kept_R7: assert (result_o == opnd_i && flags_o[0] == flags_i[0])
                    else $error("bit test changed operand or carry");
                assert_test_zp_equal_R7: assert (flags_o[6] == flags_o[2] && flags_o[4] && !flags_o[1])
                    else $error("bit test Z/P/H/N rule");
                assert_test_sign_R8: assert (!flags_o[7] || bit_idx_i == 3'd7)
                    else $error("bit test sign with index below 7");
            end
            if (grp_i[1]) begin
                assert_clrset_flags_kept_R10: assert (flags_o == flags_i)
                    else $error("clear/set changed flags");
                assert_clrset_one_bit_R10: assert ($countones(result_o ^ opnd_i) <= 1)
                    else $error("clear/set touched more than one bit");
            end
        end
    end
endmodule

bind rsb_unit rsb_unit_chk u_chk (.*);

// File: tb/sim_rsb_unit.sv
module sim_rsb_unit;
    logic clk = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic [7:0] opnd, addr_hi, flags_in, result, flags_out;
    logic [1:0] grp;
    logic [2:0] kind, idx;
    logic       acc, mem;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    rsb_unit u0 (
        .opnd_i(opnd), .grp_i(grp), .kind_i(kind), .bit_idx_i(idx),
        .acc_form_i(acc), .mem_form_i(mem), .addr_hi_i(addr_hi),
        .flags_i(flags_in), .result_o(result), .flags_o(flags_out)
    );

    // Reference model written from the requirements.
    function automatic logic [15:0] model(input logic [7:0] a, input logic [1:0] g,
                                          input logic [2:0] k, input logic [2:0] n,
                                          input logic af, input logic mf,
                                          input logic [7:0] hb, input logic [7:0] f);
        logic [7:0] r, fo;
        logic c;
        r = a; fo = f; c = f[0];
        if (g == 2'd0) begin
            case (k)
                3'd0: begin c = a[7]; r = (a << 1) | {7'd0, a[7]}; end
                3'd1: begin c = a[0]; r = (a >> 1) | {a[0], 7'd0}; end
                3'd2: begin c = a[7]; r = (a << 1) | {7'd0, f[0]}; end
                3'd3: begin c = a[0]; r = (a >> 1) | {f[0], 7'd0}; end
                3'd4: begin c = a[7]; r = a << 1; end
                3'd5: begin c = a[0]; r = (a >> 1) | (a & 8'h80); end
                3'd6: begin c = a[7]; r = (a << 1) | 8'h01; end
                default: begin c = a[0]; r = a >> 1; end
            endcase
            fo[0] = c; fo[1] = 1'b0; fo[4] = 1'b0; fo[3] = r[3]; fo[5] = r[5];
            if (!af) begin
                fo[7] = r[7]; fo[6] = (r == 8'd0); fo[2] = ($countones(r) % 2 == 0);
            end
        end else if (g == 2'd1) begin
            fo[6] = (a[n] == 1'b0); fo[2] = fo[6];
            fo[7] = (n == 3'd7) && a[7];
            fo[4] = 1'b1; fo[1] = 1'b0;
            fo[3] = mf ? hb[3] : a[3]; fo[5] = mf ? hb[5] : a[5];
        end else begin
            r[n] = (g == 2'd3);
        end
        return {r, fo};
    endfunction

    function automatic string tag_of(input logic [1:0] g, input logic [2:0] k,
                                     input logic af, input bit is_flag);
        if (g == 2'd0) begin
            if (is_flag) return af ? "R6" : "R5";
            if (k < 3'd2) return "R1";
            if (k < 3'd4) return "R2";
            if (k == 3'd6) return "R4";
            return "R3";
        end
        if (g == 2'd1) return is_flag ? "R7/R8/R9" : "R7";
        return "R10";
    endfunction

    task automatic apply(input logic [7:0] a, input logic [1:0] g, input logic [2:0] k,
                         input logic [2:0] n, input logic af, input logic mf,
                         input logic [7:0] hb, input logic [7:0] f);
        logic [15:0] exp;
        @(posedge clk);
        opnd = a; grp = g; kind = k; idx = n; acc = af; mem = mf; addr_hi = hb; flags_in = f;
        @(negedge clk);
        exp = model(a, g, k, n, af, mf, hb, f);
        checks++;
        if (result !== exp[15:8]) begin
            errors++;
            $display("FAIL %s result: actual %02h expected %02h (op=%0d/%0d a=%02h)",
                     tag_of(g, k, af, 1'b0), result, exp[15:8], g, k, a);
        end
        checks++;
        if (flags_out !== exp[7:0]) begin
            errors++;
            $display("FAIL %s flags: actual %02h expected %02h (op=%0d/%0d a=%02h n=%0d)",
                     tag_of(g, k, af, 1'b1), flags_out, exp[7:0], g, k, a, n);
        end
    endtask

    initial begin
        fork
            begin
                // Idle state: clear-bit 0 of zero with zero flags.
                apply(8'h00, 2'd2, 3'd0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
                // R1 circular rotates
                apply(8'h81, 2'd0, 3'd0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
                apply(8'h01, 2'd0, 3'd1, 3'd0, 1'b0, 1'b0, 8'h00, 8'hFF);
                // R2 through-carry with both carry-in values
                for (int c = 0; c < 2; c++) begin
                    apply(8'h80, 2'd0, 3'd2, 3'd0, 1'b0, 1'b0, 8'h00, 8'(c));
                    apply(8'h01, 2'd0, 3'd3, 3'd0, 1'b0, 1'b0, 8'h00, 8'(c));
                end
                // R3 fills: SLA, SRA of negative, SRL
                apply(8'hFF, 2'd0, 3'd4, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
                apply(8'h80, 2'd0, 3'd5, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
                apply(8'h01, 2'd0, 3'd7, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
                // R4 SLL fill one
                apply(8'h80, 2'd0, 3'd6, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
                // R5 zero result and parity
                apply(8'h80, 2'd0, 3'd4, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
                // R6 accumulator form keeps S/Z/P
                apply(8'h80, 2'd0, 3'd0, 3'd0, 1'b1, 1'b0, 8'h00, 8'h44);
                apply(8'h00, 2'd0, 3'd2, 3'd0, 1'b1, 1'b0, 8'h00, 8'h80);
                // R7 and R8 bit test index 7, both values
                apply(8'h80, 2'd1, 3'd0, 3'd7, 1'b0, 1'b0, 8'h00, 8'h01);
                apply(8'h7F, 2'd1, 3'd0, 3'd7, 1'b0, 1'b0, 8'h00, 8'h00);
                // R9 memory form X/Y from the address byte
                apply(8'h00, 2'd1, 3'd0, 3'd2, 1'b0, 1'b1, 8'h28, 8'h00);
                apply(8'h28, 2'd1, 3'd0, 3'd3, 1'b0, 1'b1, 8'h00, 8'h00);
                // R10 clear/set
                apply(8'hFF, 2'd2, 3'd0, 3'd5, 1'b0, 1'b0, 8'h00, 8'hA5);
                apply(8'h00, 2'd3, 3'd0, 3'd7, 1'b0, 1'b0, 8'h00, 8'h5A);
                // Random mix
                void'($urandom(32'd20240611));
                for (int i = 0; i < 3000; i++) begin
                    apply(8'($urandom), 2'($urandom), 3'($urandom), 3'($urandom),
                          ($urandom % 4) == 0, 1'($urandom), 8'($urandom), 8'($urandom));
                end
                done = 1'b1;
            end
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
        join_any
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule